// File: doc/BRIEF.md
# Serial DAC Command Front End

This block is the digital side of an eight-channel voltage-output converter. A host sends 32-bit command frames over three wires: an active-low frame sync, a serial clock and a data line. Each frame carries an opcode, a channel address and a 16-bit code. The block keeps a staged (input) register and a live (output) register per channel, a programmable clear value, and a per-channel mask for the load strobe. It presents the eight live codes to the analog converters.

The serial pins, the load strobe and the clear pin are asynchronous to the system clock. Each passes through a two-flop synchroniser, and serial clock falling edges are found in the system-clock domain. The serial clock must therefore run at no more than a quarter of the system-clock rate. Everything moves at a fixed pipeline depth, so there is no back-pressure and no stream handshake at any edge. The host paces frames itself, and the live codes are plain levels.

Top module: `dac_cmd_front`

## Requirements
- R1: After reset every live code reads 0, and the clear value is 0, so a clear pulse straight after reset leaves every live code at 0.
- R2: Data is taken on falling serial clock edges while frame sync is low, most significant bit first. On the 32nd edge the frame is decoded as: bits 27..24 opcode, bits 23..20 channel address, bits 19..4 code. Opcode 3 writes the code into the addressed channel's staged and live registers.
- R3: Opcode 0 writes only the staged register of the addressed channel and leaves every live code unchanged. Opcode 1 copies staged to live for the addressed channel.
- R4: Opcode 2 writes the staged register of the addressed channel, then copies staged to live for all eight channels.
- R5: Address 15 selects all eight channels. Addresses 8 to 14 select no channel, so data frames sent to them change nothing.
- R6: A frame whose sync rises after fewer than 32 falling edges is discarded with no register change. This covers both a 20-edge frame and a 31-edge frame.
- R7: Falling edges after the 32nd within the same sync-low period are ignored and cause no second write.
- R8: Opcode 5 loads the code into the clear value without changing the live codes. While the clear pin is low, all staged and live registers take the clear value.
- R9: A clear pulse during a frame aborts it. The edges that follow in the same sync-low period do not complete a frame.
- R10: A falling edge on the load strobe copies staged to live for every channel whose mask bit is 0, at any time.
- R11: If the load strobe is low when a frame completes, staged is copied to live for every unmasked channel right after that frame's write.
- R12: Opcode 6 loads the mask from code bits 7..0 (frame bits 11..4). Mask bit n set means channel n ignores the load strobe.
- R13: Opcodes 4 and 7 to 15 change no register.
- R14: Frame bits 31..28 and 3..0 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sync_n | input | 1 | Frame sync, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous, at most clk/4 |
| sdin | input | 1 | Serial data, sampled on sclk falling edges |
| load_n | input | 1 | Load strobe, active low, asynchronous |
| clr_n | input | 1 | Clear, active low, asynchronous |
| dac_code | output | 128 | Live codes; channel n at bits 16n+15..16n |

## Verification
Frames are sent with 32 edges, with 20 and 31 edges, and with 37 edges. This separates correct framing from an off-by-one edge count and from a shifter that keeps running after the frame ends. The staged-only, single-copy, copy-all and write-through opcodes are each sent on their own, against single, broadcast and out-of-range addresses. This shows which register each opcode reaches. The load strobe is tested idle-to-low outside a frame and held low across a frame, with and without a mask. Clear is tested both between frames and in the middle of a frame, which separates a plain clear from an abort.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int FRAME_W = 32;
  localparam int CODE_W  = 16;
  localparam int ADDR_W  = 4;
  localparam int OP_W    = 4;
  localparam logic [ADDR_W-1:0] ADDR_ALL = '1;

  typedef enum logic [OP_W-1:0] {
    OP_STAGE     = 4'd0,
    OP_COPY      = 4'd1,
    OP_STAGE_ALL = 4'd2,
    OP_WRITE_ONE = 4'd3,
    OP_CLR_VAL   = 4'd5,
    OP_MASK      = 4'd6
  } op_e;

  typedef struct packed {
    logic [3:0]        pre;
    logic [OP_W-1:0]   op;
    logic [ADDR_W-1:0] addr;
    logic [CODE_W-1:0] code;
    logic [3:0]        tail;
  } frame_t;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/dcf_shifter.sv
module dcf_shifter
  import dcf_pkg::*;
#(
  parameter int FW = FRAME_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_n_s,
  input  logic          sclk_s,
  input  logic          sdin_s,
  input  logic          abort_i,
  output logic          done_o,
  output logic [FW-1:0] frame_o
);
  localparam int CNT_W = $clog2(FW + 1);

  logic             sclk_prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic [FW-2:0]    shift_q;
  logic             fall;

  assign fall = sclk_prev_q & ~sclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b1;
      cnt_q       <= '0;
      shift_q     <= '0;
      done_o      <= 1'b0;
      frame_o     <= '0;
    end else begin
      sclk_prev_q <= sclk_s;
      done_o      <= 1'b0;
      if (sync_n_s || abort_i) begin
        cnt_q <= '0;
      end else if (fall && (cnt_q < CNT_W'(FW))) begin
        shift_q <= {shift_q[FW-3:0], sdin_s};
        cnt_q   <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(FW - 1)) begin
          done_o  <= 1'b1;
          frame_o <= {shift_q, sdin_s};
        end
      end
    end
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(FW));

  // R6
  done_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(!sync_n_s) && $past(!abort_i)));
endmodule

// File: rtl/dcf_regs.sv
module dcf_regs
  import dcf_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = CODE_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   done_i,
  input  logic [OP_W-1:0]        op_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DW-1:0]          code_i,
  input  logic                   load_low_i,
  input  logic                   load_fall_i,
  input  logic                   clr_i,
  output logic [NCH-1:0][DW-1:0] live_o
);
  logic [NCH-1:0][DW-1:0] stage_q, stage_d, live_d;
  logic [DW-1:0]          clr_val_q, clr_val_d;
  logic [NCH-1:0]         mask_q, mask_d;
  logic [NCH-1:0]         sel;

  always_comb begin
    for (int ch = 0; ch < NCH; ch++)
      sel[ch] = (addr_i == ADDR_ALL) || (addr_i == ADDR_W'(ch));
  end

  always_comb begin
    stage_d   = stage_q;
    live_d    = live_o;
    clr_val_d = clr_val_q;
    mask_d    = mask_q;
    if (clr_i) begin
      for (int ch = 0; ch < NCH; ch++) begin
        stage_d[ch] = clr_val_q;
        live_d[ch]  = clr_val_q;
      end
    end else begin
      if (done_i) begin
        case (op_i)
          OP_STAGE: begin
            for (int ch = 0; ch < NCH; ch++)
              if (sel[ch]) stage_d[ch] = code_i;
          end
          OP_COPY: begin
            for (int ch = 0; ch < NCH; ch++)
              if (sel[ch]) live_d[ch] = stage_q[ch];
          end
          OP_STAGE_ALL: begin
            for (int ch = 0; ch < NCH; ch++) begin
              if (sel[ch]) stage_d[ch] = code_i;
              live_d[ch] = sel[ch] ? code_i : stage_q[ch];
            end
          end
          OP_WRITE_ONE: begin
            for (int ch = 0; ch < NCH; ch++)
              if (sel[ch]) begin
                stage_d[ch] = code_i;
                live_d[ch]  = code_i;
              end
          end
          OP_CLR_VAL: clr_val_d = code_i;
          OP_MASK:    mask_d    = code_i[NCH-1:0];
          default: ;
        endcase
      end
      if ((done_i && load_low_i) || load_fall_i) begin
        for (int ch = 0; ch < NCH; ch++)
          if (!mask_q[ch]) live_d[ch] = stage_d[ch];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q   <= '0;
      live_o    <= '0;
      clr_val_q <= '0;
      mask_q    <= '0;
    end else begin
      stage_q   <= stage_d;
      live_o    <= live_d;
      clr_val_q <= clr_val_d;
      mask_q    <= mask_d;
    end
  end

  // R8
  clear_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (live_o[0] == clr_val_q && live_o[NCH-1] == clr_val_q));

  // R3
  live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_i && !load_fall_i && !clr_i) |=> $stable(live_o));

  // R12
  masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q[0] && load_fall_i && !done_i && !clr_i) |=> $stable(live_o[0]));
endmodule

// File: rtl/dac_cmd_front.sv
module dac_cmd_front
  import dcf_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_n,
  input  logic              sclk,
  input  logic              sdin,
  input  logic              load_n,
  input  logic              clr_n,
  output logic [NCH*DW-1:0] dac_code
);
  localparam int NSYNC = 5;

  logic [NSYNC-1:0]       pins_s;
  logic                   sync_n_s, sclk_s, sdin_s, load_n_s, clr_n_s;
  logic                   load_prev_q;
  logic                   done;
  logic [FRAME_W-1:0]     frame_w;
  frame_t                 fr;
  logic [NCH-1:0][DW-1:0] live;
  logic                   unused_bits;

  dcf_sync #(.W(NSYNC), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({sync_n, sclk, sdin, load_n, clr_n}),
    .q_o(pins_s)
  );
  assign {sync_n_s, sclk_s, sdin_s, load_n_s, clr_n_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_prev_q <= 1'b1;
    else        load_prev_q <= load_n_s;
  end

  dcf_shifter #(.FW(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sync_n_s(sync_n_s), .sclk_s(sclk_s), .sdin_s(sdin_s),
    .abort_i(!clr_n_s),
    .done_o(done), .frame_o(frame_w)
  );

  assign fr          = frame_t'(frame_w);
  assign unused_bits = ^{fr.pre, fr.tail};

  dcf_regs #(.NCH(NCH), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .done_i(done), .op_i(fr.op), .addr_i(fr.addr), .code_i(fr.code[DW-1:0]),
    .load_low_i(!load_n_s), .load_fall_i(load_prev_q && !load_n_s),
    .clr_i(!clr_n_s),
    .live_o(live)
  );

  assign dac_code = live;

  // R9
  abort_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n_s |=> !done);
endmodule

// File: tb/sim_dac_cmd_front.sv
module sim_dac_cmd_front;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_n = 1'b1, sclk = 1'b1, sdin = 1'b0, load_n = 1'b1, clr_n = 1'b1;
  logic [127:0] dac_code;

  always #4 clk = ~clk;

  dac_cmd_front u0 (.clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk),
    .sdin(sdin), .load_n(load_n), .clr_n(clr_n), .dac_code(dac_code));

  typedef struct { int ch; logic [15:0] val; string req; } exp_t;
  exp_t exp_q[$];
  int total = 0, bad = 0;
  bit finished = 0;

  logic [15:0] m_stage [8];
  logic [15:0] m_live [8];
  logic [15:0] m_clr;
  logic [7:0]  m_mask;

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      total++;
      if (dac_code[e.ch*16 +: 16] !== e.val) begin
        bad++;
        $display("FAIL %s ch%0d actual=%h expected=%h", e.req, e.ch,
                 dac_code[e.ch*16 +: 16], e.val);
      end
    end
  end

  task automatic check_all(input string req);
    for (int c = 0; c < 8; c++) begin
      exp_t e;
      e.ch = c; e.val = m_live[c]; e.req = req;
      exp_q.push_back(e);
    end
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  function automatic logic [31:0] mk(input logic [3:0] op, input logic [3:0] a,
                                     input logic [15:0] d);
    return {4'hA, op, a, d, 4'h5};
  endfunction

  function automatic void m_transfer();
    for (int c = 0; c < 8; c++) if (!m_mask[c]) m_live[c] = m_stage[c];
  endfunction

  function automatic void m_frame(input logic [31:0] w, input bit load_low);
    logic [3:0] op, a; logic [15:0] d;
    op = w[27:24]; a = w[23:20]; d = w[19:4];
    for (int c = 0; c < 8; c++) begin
      bit s;
      s = (a == 4'hF) || (a == 4'(c));
      case (op)
        4'd0: if (s) m_stage[c] = d;
        4'd1: if (s) m_live[c] = m_stage[c];
        4'd2: begin if (s) m_stage[c] = d; m_live[c] = m_stage[c]; end
        4'd3: if (s) begin m_stage[c] = d; m_live[c] = d; end
        default: ;
      endcase
    end
    if (op == 4'd5) m_clr = d;
    if (op == 4'd6) m_mask = d[7:0];
    if (load_low) m_transfer();
  endfunction

  function automatic void m_clear();
    for (int c = 0; c < 8; c++) begin m_stage[c] = m_clr; m_live[c] = m_clr; end
  endfunction

  task automatic shift(input logic [31:0] w, input int nedges, input int clr_at);
    @(negedge clk); sync_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < nedges; i++) begin
      sclk = 1'b1; sdin = (i < 32) ? w[31-i] : 1'b1;
      if (i == clr_at) begin
        clr_n = 1'b0; repeat (4) @(negedge clk);
        clr_n = 1'b1; repeat (4) @(negedge clk);
      end
      repeat (3) @(negedge clk); sclk = 1'b0;
      repeat (3) @(negedge clk);
    end
    sclk = 1'b1; repeat (3) @(negedge clk);
    sync_n = 1'b1; repeat (10) @(negedge clk);
  endtask

  task automatic frame(input logic [31:0] w);
    shift(w, 32, -1);
    m_frame(w, 1'b0);
  endtask

  task automatic strobe();
    @(negedge clk); load_n = 1'b0; repeat (4) @(negedge clk);
    load_n = 1'b1; repeat (8) @(negedge clk);
    m_transfer();
  endtask

  task automatic clear_pulse();
    @(negedge clk); clr_n = 1'b0; repeat (4) @(negedge clk);
    clr_n = 1'b1; repeat (8) @(negedge clk);
    m_clear();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 8; c++) begin m_stage[c] = '0; m_live[c] = '0; end
    m_clr = '0; m_mask = '0;
    repeat (5) @(negedge clk); rst_n = 1'b1; repeat (5) @(negedge clk);
    check_all("R1 reset");
    clear_pulse(); check_all("R1 clear value zero");

    frame(mk(4'd3, 4'd2, 16'h1234)); check_all("R2 R14 write-through ch2");
    frame(mk(4'd0, 4'd5, 16'h5555)); check_all("R3 stage only");
    frame(mk(4'd1, 4'd5, 16'h0000)); check_all("R3 copy ch5");
    frame(mk(4'd0, 4'hF, 16'h0F0F)); check_all("R5 broadcast stage");
    frame(mk(4'd1, 4'hF, 16'h0000)); check_all("R5 broadcast copy");
    frame(mk(4'd3, 4'd9, 16'h9999)); check_all("R5 out-of-range addr");
    frame(mk(4'd0, 4'd1, 16'hAAAA));
    frame(mk(4'd2, 4'd3, 16'h3333)); check_all("R4 stage and copy all");

    shift(mk(4'd3, 4'd0, 16'hDEAD), 20, -1); check_all("R6 20-edge frame");
    shift(mk(4'd3, 4'd0, 16'hDEAD), 31, -1); check_all("R6 31-edge frame");
    shift(mk(4'd3, 4'd4, 16'hBEEF), 37, -1); m_frame(mk(4'd3, 4'd4, 16'hBEEF), 1'b0);
    check_all("R7 extra edges");

    frame(mk(4'd4, 4'hF, 16'h4444));
    frame(mk(4'd7, 4'hF, 16'h7777));
    frame(mk(4'd9, 4'hF, 16'h9999)); check_all("R13 unused opcodes");
    frame(mk(4'd1, 4'hF, 16'h0000)); check_all("R13 staged untouched");

    frame(mk(4'd0, 4'd6, 16'h6666));
    frame(mk(4'd6, 4'd0, 16'h0040));
    frame(mk(4'd0, 4'd7, 16'h7777));
    strobe(); check_all("R10 R12 masked strobe");
    frame(mk(4'd6, 4'd0, 16'h0000));
    strobe(); check_all("R10 unmasked strobe");

    @(negedge clk); load_n = 1'b0; repeat (8) @(negedge clk); m_transfer();
    shift(mk(4'd0, 4'd0, 16'h1111), 32, -1); m_frame(mk(4'd0, 4'd0, 16'h1111), 1'b1);
    load_n = 1'b1; repeat (8) @(negedge clk);
    check_all("R11 held strobe at frame end");

    frame(mk(4'd5, 4'd0, 16'hC0DE)); check_all("R8 clear value write");
    clear_pulse(); check_all("R8 clear pin");
    frame(mk(4'd1, 4'hF, 16'h0000)); check_all("R8 staged cleared");

    frame(mk(4'd0, 4'hF, 16'h5A5A));
    shift(mk(4'd3, 4'd2, 16'h2222), 32, 20); m_clear();
    check_all("R9 aborted frame");
    frame(mk(4'd3, 4'd2, 16'h2222)); check_all("R9 next frame accepted");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule